// File: doc/BRIEF.md
# Loss-Priority Cell Queue Admission Controller

This block governs admission to a transmit queue that holds up to a fixed number of whole cells (128 by default). Cells arrive as word streams framed by start and end markers, and the first word carries the cell's loss-priority (CLP) bit. On that first word the block decides once whether the cell enters the queue. A CLP-1 cell is refused while the stored cell count is above a programmable fill limit. A CLP-0 cell is refused only when the queue is completely full. A refused cell is dropped whole: none of its words are written.

The block does not store cell contents. It drives the write strobe, slot and word index for an external cell memory and tracks the read side through a one-cycle "cell consumed" request. It counts complete cells and keeps two sticky flags: one for CLP threshold discards and one for losses at a full queue. An interrupt is raised when a set flag's enable bit is also set. The flags clear on write-one-to-clear.

Top module: `cq_clp_queue`

## Requirements
- R1: After reset, `occupancy` is 0, `status` is 2'b00, `irq` is 0 and `mem_wr_en` is 0.
- R2: A cell whose first word has `in_clp`=0 is admitted whenever `occupancy` is below DEPTH, whatever `fill_limit` holds.
- R3: A cell whose first word has `in_clp`=1 is admitted only when `occupancy` is not greater than `fill_limit` and below DEPTH. Otherwise it is refused and `status` bit 0 (CLP discard) becomes 1 in the cycle after that first word.
- R4: A cell that starts while `occupancy` equals DEPTH is refused whatever its CLP bit. `status` bit 1 (overrun) becomes 1 in the cycle after that first word, and `occupancy` stays at DEPTH.
- R5: The verdict is taken on the first word and applies to the whole cell. Every word of an admitted cell has `mem_wr_en`=1, and `mem_wr_word` runs 0, 1, … from the first word. No word of a refused cell has `mem_wr_en`=1.
- R6: `occupancy` counts complete cells. It rises by one in the cycle after the end word of an admitted cell, and falls by one in the cycle after `rd_cell` while it is nonzero. A `rd_cell` request at 0 has no effect on `occupancy` or `rd_slot`.
- R7: When an admitted end word and an effective `rd_cell` fall in the same cycle, `occupancy` is unchanged.
- R8: A 1 in `stat_clr` bit k clears `status` bit k in the next cycle. A discard event for the same bit in that same cycle wins, and the bit stays 1. Status bits are otherwise sticky.
- R9: `irq` is 1 exactly when some `status` bit k and `irq_en` bit k are both 1.
- R10: `mem_wr_slot` advances by one slot per admitted cell and `rd_slot` advances by one per effective read. Both wrap from DEPTH-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming word present |
| in_sop | input | 1 | First word of a cell |
| in_eop | input | 1 | Last word of a cell |
| in_clp | input | 1 | Loss-priority bit, sampled with the first word |
| fill_limit | input | CW | CLP-1 admission limit in cells |
| mem_wr_en | output | 1 | Write strobe for the current word |
| mem_wr_slot | output | PW | Slot receiving the cell being written |
| mem_wr_word | output | WW | Word index within that slot |
| rd_cell | input | 1 | Head cell consumed request |
| rd_slot | output | PW | Slot of the head cell |
| occupancy | output | CW | Complete cells stored |
| irq_en | input | 2 | Interrupt enables (bit 0 CLP discard, bit 1 overrun) |
| stat_clr | input | 2 | Write-one-to-clear strobes for the status bits |
| status | output | 2 | Sticky flags (bit 0 CLP discard, bit 1 overrun) |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with DEPTH=8 and CELL_WORDS=2. With these values the queue can be filled to capacity in a few dozen cycles, so the full-queue loss, the fill-limit boundary (fill limit 3 and fill limit 8, equal to DEPTH), and slot-pointer wrap are all reached. Two-word cells let the bench show that the first-word verdict holds over the end word, and let an end word coincide with a read. DEPTH=8 is a power of two, so the bench uses the natural-wrap pointer variant.

// File: rtl/cq_pkg.sv
package cq_pkg;

   typedef enum logic [1:0] {
      ADM_ACCEPT    = 2'd0,
      ADM_CLP_DROP  = 2'd1,
      ADM_FULL_DROP = 2'd2
   } adm_verdict_e;

   localparam int FLAG_CLP = 0;
   localparam int FLAG_OVR = 1;
   localparam int NFLAGS   = 2;

endpackage

// File: rtl/cq_admit.sv
module cq_admit
   import cq_pkg::*;
#(
   parameter int DEPTH      = 128,
   parameter int CELL_WORDS = 14,
   localparam int CW = $clog2(DEPTH + 1),
   localparam int WW = (CELL_WORDS > 1) ? $clog2(CELL_WORDS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic          in_sop,
   input  logic          in_eop,
   input  logic          in_clp,
   input  logic [CW-1:0] occ,
   input  logic [CW-1:0] fill_limit,
   output logic          wr_en,
   output logic [WW-1:0] wr_word,
   output logic          cell_done,
   output logic          clp_drop,
   output logic          ovr_drop
);

   localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
   localparam logic [WW-1:0] LAST_W  = WW'(CELL_WORDS - 1);

   adm_verdict_e  verdict;
   logic          start;
   logic          keep_now;
   logic          keep_q;
   logic [WW-1:0] word_q;
   logic [WW-1:0] word_cur;
   logic [WW-1:0] word_nxt;

   // Verdict for a cell, evaluated on its first word only.
   always_comb begin
      verdict = ADM_ACCEPT;
      if (occ >= DEPTH_C)
         verdict = ADM_FULL_DROP;
      else if (in_clp && (occ > fill_limit))
         verdict = ADM_CLP_DROP;
   end

   assign start     = in_valid & in_sop;
   assign keep_now  = start ? (verdict == ADM_ACCEPT) : keep_q;
   assign wr_en     = in_valid & keep_now;
   assign cell_done = wr_en & in_eop;
   assign clp_drop  = start & (verdict == ADM_CLP_DROP);
   assign ovr_drop  = start & (verdict == ADM_FULL_DROP);

   assign word_cur = start ? '0 : word_q;
   assign wr_word  = word_cur;

   always_comb begin
      if (word_cur == LAST_W)
         word_nxt = word_cur;
      else
         word_nxt = word_cur + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         keep_q <= 1'b0;
         word_q <= '0;
      end else if (in_valid) begin
         keep_q <= in_eop ? 1'b0 : keep_now;
         if (in_eop)
            word_q <= '0;
         else if (wr_en)
            word_q <= word_nxt;
      end
   end

endmodule

// File: rtl/cq_occupancy.sv
module cq_occupancy #(
   parameter int DEPTH = 128,
   localparam int CW = $clog2(DEPTH + 1),
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop_req,
   output logic [CW-1:0] occ,
   output logic [PW-1:0] wr_slot,
   output logic [PW-1:0] rd_slot
);

   localparam bit            POW2   = (DEPTH & (DEPTH - 1)) == 0;
   localparam logic [PW-1:0] LAST_S = PW'(DEPTH - 1);

   logic          pop;
   logic [PW-1:0] wr_nxt;
   logic [PW-1:0] rd_nxt;

   assign pop = pop_req & (occ != '0);

   generate
      if (POW2) begin : g_wrap_natural
         assign wr_nxt = wr_slot + 1'b1;
         assign rd_nxt = rd_slot + 1'b1;
      end else begin : g_wrap_compare
         assign wr_nxt = (wr_slot == LAST_S) ? '0 : wr_slot + 1'b1;
         assign rd_nxt = (rd_slot == LAST_S) ? '0 : rd_slot + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         occ     <= '0;
         wr_slot <= '0;
         rd_slot <= '0;
      end else begin
         case ({push, pop})
            2'b10:   occ <= occ + 1'b1;
            2'b01:   occ <= occ - 1'b1;
            default: occ <= occ;
         endcase
         if (push) wr_slot <= wr_nxt;
         if (pop)  rd_slot <= rd_nxt;
      end
   end

endmodule

// File: rtl/cq_status.sv
module cq_status #(
   parameter int NF = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NF-1:0] set,
   input  logic [NF-1:0] clr,
   input  logic [NF-1:0] en,
   output logic [NF-1:0] flags,
   output logic          irq
);

   logic [NF-1:0] flags_nxt;

   generate
      for (genvar g = 0; g < NF; g++) begin : g_flag
         // A new event outranks a clear strobe in the same cycle.
         assign flags_nxt[g] = set[g] | (flags[g] & ~clr[g]);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         flags <= '0;
      else
         flags <= flags_nxt;
   end

   assign irq = |(flags & en);

endmodule

// File: rtl/cq_clp_queue.sv
module cq_clp_queue
   import cq_pkg::*;
#(
   parameter int DEPTH      = 128,
   parameter int CELL_WORDS = 14,
   localparam int CW = $clog2(DEPTH + 1),
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int WW = (CELL_WORDS > 1) ? $clog2(CELL_WORDS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic          in_sop,
   input  logic          in_eop,
   input  logic          in_clp,
   input  logic [CW-1:0] fill_limit,
   output logic          mem_wr_en,
   output logic [PW-1:0] mem_wr_slot,
   output logic [WW-1:0] mem_wr_word,
   input  logic          rd_cell,
   output logic [PW-1:0] rd_slot,
   output logic [CW-1:0] occupancy,
   input  logic [1:0]    irq_en,
   input  logic [1:0]    stat_clr,
   output logic [1:0]    status,
   output logic          irq
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("cq_clp_queue: DEPTH must be at least 2");
      end
      if (CELL_WORDS < 1) begin : g_bad_words
         $error("cq_clp_queue: CELL_WORDS must be at least 1");
      end
   endgenerate

   logic              cell_done;
   logic              clp_drop;
   logic              ovr_drop;
   logic [NFLAGS-1:0] events;

   cq_admit #(
      .DEPTH      (DEPTH),
      .CELL_WORDS (CELL_WORDS)
   ) u_admit (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_sop     (in_sop),
      .in_eop     (in_eop),
      .in_clp     (in_clp),
      .occ        (occupancy),
      .fill_limit (fill_limit),
      .wr_en      (mem_wr_en),
      .wr_word    (mem_wr_word),
      .cell_done  (cell_done),
      .clp_drop   (clp_drop),
      .ovr_drop   (ovr_drop)
   );

   cq_occupancy #(
      .DEPTH (DEPTH)
   ) u_occ (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (cell_done),
      .pop_req (rd_cell),
      .occ     (occupancy),
      .wr_slot (mem_wr_slot),
      .rd_slot (rd_slot)
   );

   always_comb begin
      events           = '0;
      events[FLAG_CLP] = clp_drop;
      events[FLAG_OVR] = ovr_drop;
   end

   cq_status #(
      .NF (NFLAGS)
   ) u_status (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (events),
      .clr   (stat_clr),
      .en    (irq_en),
      .flags (status),
      .irq   (irq)
   );

endmodule

// File: rtl/cq_clp_queue_chk.sv
module cq_clp_queue_chk #(
   parameter int DEPTH = 128,
   parameter int CW    = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic          in_sop,
   input logic          in_eop,
   input logic          in_clp,
   input logic [CW-1:0] fill_limit,
   input logic          mem_wr_en,
   input logic          rd_cell,
   input logic [CW-1:0] occupancy,
   input logic [1:0]    irq_en,
   input logic [1:0]    stat_clr,
   input logic [1:0]    status,
   input logic          irq
);

   localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

   a_r2_clp0_admitted: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sop && !in_clp && occupancy < DEPTH_C) |-> mem_wr_en);

   a_r3_clp1_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sop && in_clp && occupancy > fill_limit) |-> !mem_wr_en);

   a_r4_full_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sop && occupancy == DEPTH_C) |-> !mem_wr_en);

   a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      occupancy <= DEPTH_C);

   a_r6_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_cell && occupancy == '0 && !(mem_wr_en && in_eop)) |=> occupancy == '0);

   a_r7_balanced: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_en && in_eop && rd_cell && occupancy != '0) |=> $stable(occupancy));

   a_r8_sticky_clp: assert property (@(posedge clk) disable iff (!rst_n)
      (status[0] && !stat_clr[0]) |=> status[0]);

   a_r8_sticky_ovr: assert property (@(posedge clk) disable iff (!rst_n)
      (status[1] && !stat_clr[1]) |=> status[1]);

   a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en == 2'b00) |-> !irq);

endmodule

bind cq_clp_queue cq_clp_queue_chk #(
   .DEPTH (DEPTH),
   .CW    (CW)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_sop     (in_sop),
   .in_eop     (in_eop),
   .in_clp     (in_clp),
   .fill_limit (fill_limit),
   .mem_wr_en  (mem_wr_en),
   .rd_cell    (rd_cell),
   .occupancy  (occupancy),
   .irq_en     (irq_en),
   .stat_clr   (stat_clr),
   .status     (status),
   .irq        (irq)
);

// File: tb/cq_clp_queue_tb.sv
`timescale 1ns/1ps
module cq_clp_queue_tb_top;

   localparam int DEPTH = 8;
   localparam int CELL_WORDS = 2;
   localparam int CW = $clog2(DEPTH + 1);
   localparam int PW = $clog2(DEPTH);
   localparam int WW = 1;
   localparam int NV = 20;

   // Vector: [10] 1=read 0=write, [9] clp, [8] expected admit, [7:0] expected occupancy
   localparam logic [10:0] VEC [NV] = '{
      {1'b0, 1'b1, 1'b1, 8'd1},
      {1'b0, 1'b1, 1'b1, 8'd2},
      {1'b0, 1'b1, 1'b1, 8'd3},
      {1'b0, 1'b1, 1'b1, 8'd4},
      {1'b0, 1'b1, 1'b0, 8'd4},
      {1'b0, 1'b0, 1'b1, 8'd5},
      {1'b1, 1'b0, 1'b0, 8'd4},
      {1'b0, 1'b1, 1'b0, 8'd4},
      {1'b1, 1'b0, 1'b0, 8'd3},
      {1'b0, 1'b1, 1'b1, 8'd4},
      {1'b0, 1'b0, 1'b1, 8'd5},
      {1'b0, 1'b0, 1'b1, 8'd6},
      {1'b0, 1'b0, 1'b1, 8'd7},
      {1'b0, 1'b0, 1'b1, 8'd8},
      {1'b0, 1'b0, 1'b0, 8'd8},
      {1'b0, 1'b1, 1'b0, 8'd8},
      {1'b1, 1'b0, 1'b0, 8'd7},
      {1'b1, 1'b0, 1'b0, 8'd6},
      {1'b0, 1'b1, 1'b0, 8'd6},
      {1'b0, 1'b0, 1'b1, 8'd7}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_sop = 1'b0;
   logic          in_eop = 1'b0;
   logic          in_clp = 1'b0;
   logic [CW-1:0] fill_limit = CW'(3);
   logic          mem_wr_en;
   logic [PW-1:0] mem_wr_slot;
   logic [WW-1:0] mem_wr_word;
   logic          rd_cell = 1'b0;
   logic [PW-1:0] rd_slot;
   logic [CW-1:0] occupancy;
   logic [1:0]    irq_en = 2'b00;
   logic [1:0]    stat_clr = 2'b00;
   logic [1:0]    status;
   logic          irq;

   int n_checks = 0;
   int n_fail = 0;
   int n_acc = 0;
   int n_rd = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   cq_clp_queue #(
      .DEPTH      (DEPTH),
      .CELL_WORDS (CELL_WORDS)
   ) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_sop      (in_sop),
      .in_eop      (in_eop),
      .in_clp      (in_clp),
      .fill_limit  (fill_limit),
      .mem_wr_en   (mem_wr_en),
      .mem_wr_slot (mem_wr_slot),
      .mem_wr_word (mem_wr_word),
      .rd_cell     (rd_cell),
      .rd_slot     (rd_slot),
      .occupancy   (occupancy),
      .irq_en      (irq_en),
      .stat_clr    (stat_clr),
      .status      (status),
      .irq         (irq)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic write_cell(input logic clp, input logic rd_at_eop, input logic [1:0] clr_at_sop,
                             output logic a0, output logic a1, output logic [WW-1:0] w1);
      @(negedge clk);
      in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b0; in_clp = clp; stat_clr = clr_at_sop;
      #1 a0 = mem_wr_en;
      @(negedge clk);
      in_sop = 1'b0; in_eop = 1'b1; in_clp = 1'b0; stat_clr = 2'b00; rd_cell = rd_at_eop;
      #1 a1 = mem_wr_en; w1 = mem_wr_word;
      @(negedge clk);
      in_valid = 1'b0; in_eop = 1'b0; rd_cell = 1'b0;
   endtask

   task automatic read_cell();
      @(negedge clk);
      rd_cell = 1'b1;
      @(negedge clk);
      rd_cell = 1'b0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin : main
      logic a0, a1;
      logic [WW-1:0] w1;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      check(occupancy == 0, "R1 occupancy", int'(occupancy), 0);
      check(status == 2'b00, "R1 status", int'(status), 0);
      check(irq == 1'b0, "R1 irq", int'(irq), 0);
      check(mem_wr_en == 1'b0, "R1 mem_wr_en", int'(mem_wr_en), 0);

      // Table walk: R2, R3, R4, R5, R6 with fill limit 3
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][10]) begin
            read_cell();
            n_rd++;
         end else begin
            write_cell(VEC[i][9], 1'b0, 2'b00, a0, a1, w1);
            check(a0 == VEC[i][8], "R2/R3/R4 first-word admit", int'(a0), int'(VEC[i][8]));
            check(a1 == VEC[i][8], "R5 end-word follows verdict", int'(a1), int'(VEC[i][8]));
            if (VEC[i][8]) begin
               check(w1 == 1'b1, "R5 word index", int'(w1), 1);
               n_acc++;
            end
         end
         check(occupancy == CW'(VEC[i][7:0]), "R6 occupancy after step", int'(occupancy), int'(VEC[i][7:0]));
      end

      // R3, R4 both flags recorded by the table
      check(status == 2'b11, "R3 R4 sticky flags", int'(status), 3);

      // R9 interrupt gating
      irq_en = 2'b00; #1;
      check(irq == 1'b0, "R9 irq masked", int'(irq), 0);
      irq_en = 2'b01; #1;
      check(irq == 1'b1, "R9 irq clp enable", int'(irq), 1);
      irq_en = 2'b10; #1;
      check(irq == 1'b1, "R9 irq ovr enable", int'(irq), 1);

      // R8 clear both
      @(negedge clk); stat_clr = 2'b11;
      @(negedge clk); stat_clr = 2'b00;
      check(status == 2'b00, "R8 w1c clear", int'(status), 0);
      irq_en = 2'b11; #1;
      check(irq == 1'b0, "R9 irq after clear", int'(irq), 0);

      // R8 event beats clear: occupancy 7 > limit 3, CLP-1 refused with clear on bit 0
      write_cell(1'b1, 1'b0, 2'b01, a0, a1, w1);
      check(a0 == 1'b0, "R3 refuse above limit", int'(a0), 0);
      check(status == 2'b01, "R8 set beats clear", int'(status), 1);

      // R7 end word with a read in the same cycle
      write_cell(1'b0, 1'b1, 2'b00, a0, a1, w1);
      n_acc++; n_rd++;
      check(a0 == 1'b1 && a1 == 1'b1, "R7 cell admitted", int'({a0, a1}), 3);
      check(occupancy == CW'(7), "R7 occupancy unchanged", int'(occupancy), 7);

      // R3 limit equal to DEPTH: CLP-1 admitted at 7
      fill_limit = CW'(8);
      write_cell(1'b1, 1'b0, 2'b00, a0, a1, w1);
      n_acc++;
      check(a0 == 1'b1, "R3 admit at or below limit", int'(a0), 1);
      check(occupancy == CW'(8), "R6 occupancy full", int'(occupancy), 8);

      // R4 full with limit at DEPTH still refuses CLP-1
      write_cell(1'b1, 1'b0, 2'b00, a0, a1, w1);
      check(a0 == 1'b0 && a1 == 1'b0, "R4 full refuse", int'({a0, a1}), 0);
      check(status == 2'b11, "R4 overrun flag", int'(status), 3);

      // R6 drain and read at empty
      for (int k = 0; k < DEPTH; k++) begin
         read_cell();
         n_rd++;
      end
      check(occupancy == 0, "R6 drained", int'(occupancy), 0);
      read_cell();
      check(occupancy == 0, "R6 read at empty ignored", int'(occupancy), 0);
      check(rd_slot == PW'(n_rd % DEPTH), "R10 rd_slot wrap", int'(rd_slot), n_rd % DEPTH);
      check(mem_wr_slot == PW'(n_acc % DEPTH), "R10 wr_slot wrap", int'(mem_wr_slot), n_acc % DEPTH);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule